// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block converts a 32-bit linear address into a physical address. When translation is enabled, it walks a two-level table. The root frame register gives the frame of a page directory. The top ten address bits select a directory entry, and that entry names the frame of a page table. The next ten bits select a table entry, and that entry names the 4 KB physical frame. The low twelve bits pass through unchanged as the page offset. At each level the walker checks the entry's present flag and its access-right flags against the request. A failed check ends the walk with a fault that reports the level and the reason. When translation is disabled, the linear address is returned as it is and no memory is touched.

Requests enter on a valid/ready channel and results leave on a valid/ready channel. Table entries are fetched over a read port in two parts. The read request side uses valid/ready. The read data side is a one-cycle valid strobe, which memory may raise only after it has accepted a read. Only one walk is in flight at a time. A new request is accepted only after the previous result has been taken, so a stalled consumer holds back the request side.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, and both `rsp_valid` and `mem_rd_valid` are 0.
- R2: If `xlate_en` is 0 when a request is accepted, `rsp_phys` equals the linear address and `rsp_fault` is 0. No memory read is issued.
- R3: The first read address is `pt_root`×4096 + lin[31:22]×4. The second read address is dir_entry[31:12]×4096 + lin[21:12]×4.
- R4: A walk with no fault returns `rsp_phys` = {tbl_entry[31:12], lin[11:0]}, with `rsp_fault` = 0 and `rsp_cause` = 0.
- R5: Bit 0 of an entry is the present flag. If it is 0, the walk ends with `rsp_fault` = 1, `rsp_cause` = 1 and `rsp_phys` = 0. `rsp_fault_lvl` is 0 for the directory and 1 for the table. A directory fault issues no table read.
- R6: Bit 2 of an entry is the user-allowed flag. A user request (`req_user` = 1) that meets a 0 there, at either level, faults with `rsp_cause` = 2.
- R7: Bit 1 of an entry is the writable flag. A user write that meets a 0 there, at either level, faults with `rsp_cause` = 3. The order of checks is: present first, then user-allowed, then writable.
- R8: Supervisor requests (`req_user` = 0) ignore bits 1 and 2 at both levels.
- R9: `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready` is seen. At most one read is outstanding, and no read is issued while a result is pending.
- R10: A result stays valid and unchanged until `rsp_ready` is high. `req_ready` is high only while no walk or result is pending.
- R11: `xlate_en` and `pt_root` are sampled when the request is accepted. Changing them during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_en | input | 1 | Translation enable, sampled at request acceptance |
| pt_root | input | 20 | Frame number of the page directory |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_lin | input | 32 | Linear address |
| req_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| req_write | input | 1 | 1 = write access |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk faulted |
| rsp_fault_lvl | output | 1 | Faulting level: 0 = directory, 1 = table |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 user denied, 3 write denied |

## Verification
The bench targets the corner cases below, and each one shows up as a wrong value at the ports:
- A directory entry that is absent but whose table entry would be fine. A design that still reads the table would show two reads instead of one.
- An entry that denies both user access and write access. A design with the checks in the wrong order would report cause 3 instead of 2.
- A supervisor write against entries with bits 1 and 2 clear. A design that applies the user rules to supervisor requests would fault.
- The bench flips `xlate_en` and `pt_root` right after acceptance, and it applies random back-pressure on both the read port and the result port. A design that does not latch these inputs, or that drops a held read or result, would show a wrong address, a wrong read count or a changed result.

// File: rtl/pgwalk_pkg.sv
`timescale 1ns/1ps
package pgwalk_pkg;
  localparam int FLAG_PRESENT = 0;
  localparam int FLAG_WRITE   = 1;
  localparam int FLAG_USER    = 2;
  localparam int FLAG_W       = 3;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_PRIV   = 2'd2,
    CAUSE_WRITE  = 2'd3
  } fault_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_ISSUE,
    ST_DIR_WAIT,
    ST_TBL_ISSUE,
    ST_TBL_WAIT,
    ST_FINISH
  } walk_state_e;
endpackage

// File: rtl/pgwalk_entry_chk.sv
`timescale 1ns/1ps
module pgwalk_entry_chk
  import pgwalk_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic              user,
  input  logic              write,
  output fault_cause_e      cause
);
  // Priority: presence, then user permission, then write permission.
  always_comb begin
    if (!flags[FLAG_PRESENT])
      cause = CAUSE_ABSENT;
    else if (user && !flags[FLAG_USER])
      cause = CAUSE_PRIV;
    else if (user && write && !flags[FLAG_WRITE])
      cause = CAUSE_WRITE;
    else
      cause = CAUSE_NONE;
  end
endmodule

// File: rtl/pgwalk_ent_addr.sv
`timescale 1ns/1ps
module pgwalk_ent_addr #(
  parameter int AW        = 32,
  parameter int OFF_BITS  = 12,
  parameter int IDX_BITS  = 10,
  parameter int ENT_SHIFT = 2
) (
  input  logic [AW-OFF_BITS-1:0] frame,
  input  logic [IDX_BITS-1:0]    idx,
  output logic [AW-1:0]          addr
);
  localparam int FRAME_W = AW - OFF_BITS;
  logic [AW-1:0] base_byte;
  logic [AW-1:0] idx_byte;
  assign base_byte = {frame[FRAME_W-1:0], {OFF_BITS{1'b0}}};
  assign idx_byte  = AW'(idx) << ENT_SHIFT;
  assign addr      = base_byte + idx_byte;
endmodule

// File: rtl/pgwalk_top.sv
`timescale 1ns/1ps
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int OFF_BITS = 12,
  parameter int IDX_BITS = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xlate_en,
  input  logic [AW-OFF_BITS-1:0] pt_root,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [AW-1:0]          req_lin,
  input  logic                   req_user,
  input  logic                   req_write,
  output logic                   mem_rd_valid,
  input  logic                   mem_rd_ready,
  output logic [AW-1:0]          mem_rd_addr,
  input  logic                   mem_rsp_valid,
  input  logic [AW-1:0]          mem_rsp_data,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [AW-1:0]          rsp_phys,
  output logic                   rsp_fault,
  output logic                   rsp_fault_lvl,
  output logic [1:0]             rsp_cause
);
  localparam int FRAME_W = AW - OFF_BITS;
  localparam int LEVELS  = 2;

  walk_state_e         state_q;
  logic [AW-1:0]       lin_q;
  logic                user_q;
  logic                write_q;
  logic [FRAME_W-1:0]  base_q [LEVELS];
  logic [AW-1:0]       ent_addr [LEVELS];
  logic [AW-1:0]       phys_q;
  logic                fault_q;
  logic                lvl_q;
  fault_cause_e        cause_q;
  fault_cause_e        chk_cause;
  logic                unused_entry_bits;

  assign unused_entry_bits = ^mem_rsp_data[OFF_BITS-1:FLAG_W];

  // One entry-address generator per table level; level l indexes with
  // the l-th index field counted from the top of the linear address.
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    pgwalk_ent_addr #(
      .AW(AW), .OFF_BITS(OFF_BITS), .IDX_BITS(IDX_BITS), .ENT_SHIFT(2)
    ) u_addr (
      .frame (base_q[l]),
      .idx   (lin_q[AW-1-l*IDX_BITS -: IDX_BITS]),
      .addr  (ent_addr[l])
    );
  end

  pgwalk_entry_chk u_chk (
    .flags (mem_rsp_data[FLAG_W-1:0]),
    .user  (user_q),
    .write (write_q),
    .cause (chk_cause)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_rd_valid  = (state_q == ST_DIR_ISSUE) || (state_q == ST_TBL_ISSUE);
  assign mem_rd_addr   = (state_q == ST_TBL_ISSUE) ? ent_addr[1] : ent_addr[0];
  assign rsp_valid     = (state_q == ST_FINISH);
  assign rsp_phys      = phys_q;
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = lvl_q;
  assign rsp_cause     = cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lin_q   <= '0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
      base_q[0] <= '0;
      base_q[1] <= '0;
      phys_q  <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            lin_q     <= req_lin;
            user_q    <= req_user;
            write_q   <= req_write;
            base_q[0] <= pt_root;
            fault_q   <= 1'b0;
            lvl_q     <= 1'b0;
            cause_q   <= CAUSE_NONE;
            if (xlate_en) begin
              state_q <= ST_DIR_ISSUE;
            end else begin
              phys_q  <= req_lin;
              state_q <= ST_FINISH;
            end
          end
        end
        ST_DIR_ISSUE: if (mem_rd_ready) state_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: begin
          if (mem_rsp_valid) begin
            if (chk_cause != CAUSE_NONE) begin
              fault_q <= 1'b1;
              lvl_q   <= 1'b0;
              cause_q <= chk_cause;
              phys_q  <= '0;
              state_q <= ST_FINISH;
            end else begin
              base_q[1] <= mem_rsp_data[AW-1:OFF_BITS];
              state_q   <= ST_TBL_ISSUE;
            end
          end
        end
        ST_TBL_ISSUE: if (mem_rd_ready) state_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: begin
          if (mem_rsp_valid) begin
            lvl_q <= 1'b1;
            if (chk_cause != CAUSE_NONE) begin
              fault_q <= 1'b1;
              cause_q <= chk_cause;
              phys_q  <= '0;
            end else begin
              phys_q <= {mem_rsp_data[AW-1:OFF_BITS], lin_q[OFF_BITS-1:0]};
            end
            state_q <= ST_FINISH;
          end
        end
        ST_FINISH: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgwalk_sva.sv
`timescale 1ns/1ps
module pgwalk_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_phys,
  input logic          rsp_fault,
  input logic [1:0]    rsp_cause
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R9
  AST_RD_NOT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_rd_valid); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_phys)
      && $stable(rsp_fault) && $stable(rsp_cause)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_rd_valid); // R10
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0))); // R5
  AST_FAULT_ZERO_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_phys == '0); // R5
endmodule

bind pgwalk_top pgwalk_sva #(.AW(AW)) u_pgwalk_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_phys     (rsp_phys),
  .rsp_fault    (rsp_fault),
  .rsp_cause    (rsp_cause)
);

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b0;
  logic [19:0] pt_root = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        req_user = 1'b0;
  logic        req_write = 1'b0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_phys;
  logic        rsp_fault;
  logic        rsp_fault_lvl;
  logic [1:0]  rsp_cause;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  pgwalk_top dut_i (.*);

  typedef struct {
    logic [31:0] phys;
    logic        fault;
    logic        lvl;
    logic [1:0]  cause;
    int          reads;
    logic [31:0] dir_addr;
    logic [31:0] tbl_addr;
  } exp_t;

  function automatic logic [1:0] flag_cause(logic [31:0] e, logic u, logic w);
    if (!e[0]) return 2'd1;
    if (u && !e[2]) return 2'd2;
    if (u && w && !e[1]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic exp_t model(logic [31:0] lin, logic u, logic w, logic en,
                                 logic [19:0] root, logic [31:0] pde, logic [31:0] pte);
    exp_t r;
    r.dir_addr = {root, 12'h000} + {20'h0, lin[31:22], 2'b00};
    r.tbl_addr = {pde[31:12], 12'h000} + {20'h0, lin[21:12], 2'b00};
    r.phys = 32'h0; r.fault = 1'b0; r.lvl = 1'b0; r.cause = 2'd0; r.reads = 0;
    if (!en) begin
      r.phys = lin;
      return r;
    end
    r.reads = 1;
    r.cause = flag_cause(pde, u, w);
    if (r.cause != 2'd0) begin r.fault = 1'b1; return r; end
    r.reads = 2;
    r.lvl = 1'b1;
    r.cause = flag_cause(pte, u, w);
    if (r.cause != 2'd0) begin r.fault = 1'b1; return r; end
    r.phys = {pte[31:12], lin[11:0]};
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One walk with random back-pressure; all driving at the falling edge.
  task automatic run(input logic [31:0] lin, input logic u, input logic w,
                     input logic en, input logic [19:0] root,
                     input logic [31:0] pde, input logic [31:0] pte);
    exp_t e;
    int nrd = 0;
    int dly = 0;
    bit pend = 0;
    bit done = 0;
    bit prv_rd_hold = 0;
    bit prv_rsp_hold = 0;
    logic [31:0] prv_addr = '0;
    logic [31:0] prv_phys = '0;
    logic [31:0] pdata = '0;
    e = model(lin, u, w, en, root, pde, pte);
    @(negedge clk);
    req_valid = 1'b1; req_lin = lin; req_user = u; req_write = w;
    xlate_en = en; pt_root = root;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    xlate_en = ~en;            // R11: must not affect the walk in flight
    pt_root = ~root;
    req_lin = ~lin;
    while (!done) begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = pdata; pend = 0;
        end else dly--;
      end
      mem_rd_ready = 1'($urandom_range(0, 1));
      rsp_ready = 1'($urandom_range(0, 1));
      if (prv_rd_hold) begin
        chk("R9", "read valid held", {31'h0, mem_rd_valid}, 32'h1);
        chk("R9", "read addr held", mem_rd_addr, prv_addr);
      end
      if (prv_rsp_hold) begin
        chk("R10", "result held", {31'h0, rsp_valid}, 32'h1);
        chk("R10", "result stable", rsp_phys, prv_phys);
      end
      if (mem_rd_valid && rsp_valid) chk("R9", "read during result", 32'h1, 32'h0);
      prv_rd_hold = mem_rd_valid && !mem_rd_ready;
      prv_addr = mem_rd_addr;
      prv_rsp_hold = rsp_valid && !rsp_ready;
      prv_phys = rsp_phys;
      if (mem_rd_valid && mem_rd_ready) begin
        nrd++;
        if (nrd == 1) chk("R3", "directory read address", mem_rd_addr, e.dir_addr);
        else chk("R3", "table read address", mem_rd_addr, e.tbl_addr);
        pdata = (nrd == 1) ? pde : pte;
        pend = 1;
        dly = $urandom_range(0, 2);
      end
      if (rsp_valid && rsp_ready) begin
        done = 1;
        chk("R4", "physical address", rsp_phys, e.phys);
        chk("R5", "fault flag", {31'h0, rsp_fault}, {31'h0, e.fault});
        if (e.fault) chk("R5", "fault level", {31'h0, rsp_fault_lvl}, {31'h0, e.lvl});
        chk("R6", "fault cause", {30'h0, rsp_cause}, {30'h0, e.cause});
      end
      @(negedge clk);
    end
    mem_rsp_valid = 1'b0; mem_rd_ready = 1'b0; rsp_ready = 1'b0;
    chk("R2", "number of reads", nrd, e.reads);
    chk("R10", "ready after result taken", {31'h0, req_ready}, 32'h1);
  endtask

  function automatic logic [31:0] rand_entry();
    logic [31:0] v;
    v = $urandom;
    v[0] = ($urandom_range(0, 7) != 0);
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1", "req_ready at reset", {31'h0, req_ready}, 32'h1);
    chk("R1", "rsp_valid at reset", {31'h0, rsp_valid}, 32'h0);
    chk("R1", "mem_rd_valid at reset", {31'h0, mem_rd_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: bypass
    run(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 20'h12345, 32'h0, 32'h0);
    // R4: plain success, supervisor
    run(32'h1234_5678, 1'b0, 1'b0, 1'b1, 20'h00100, 32'h0020_0007, 32'hABCD_E007);
    // R5: absent directory entry, table entry would be fine
    run(32'h0040_1000, 1'b0, 1'b0, 1'b1, 20'h00200, 32'h0030_0006, 32'h5555_5007);
    // R5: absent table entry
    run(32'hFFC0_0FFF, 1'b1, 1'b0, 1'b1, 20'hFFFFF, 32'h0030_0007, 32'h5555_5006);
    // R6: user denied at directory
    run(32'h8000_0000, 1'b1, 1'b0, 1'b1, 20'h00300, 32'h0040_0003, 32'h1111_1007);
    // R7: user write denied at table
    run(32'h0000_3ABC, 1'b1, 1'b1, 1'b1, 20'h00400, 32'h0050_0007, 32'h2222_2005);
    // R7: both user and write denied: user cause wins
    run(32'h0000_3ABC, 1'b1, 1'b1, 1'b1, 20'h00400, 32'h0050_0001, 32'h2222_2007);
    // R8: supervisor write with flags 1 and 2 clear at both levels
    run(32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1, 20'h00500, 32'h0060_0001, 32'h3333_3001);
    for (int i = 0; i < 400; i++) begin
      run($urandom, 1'($urandom), 1'($urandom), ($urandom_range(0, 5) != 0),
          20'($urandom), rand_entry(), rand_entry());
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule